// File: doc/BRIEF.md
# Prioritised Memory Chip-Select Decoder

The decoder watches a host address together with a qualifying strobe and raises at most one chip select per cycle. The possible targets are four equal code-storage blocks, one scratch RAM, an internal I/O window and a peripheral I/O window. Each window is given by a base address and a length in addressable units. A length of zero switches the window off. The peripheral window takes part only while the peripheral-mode enable is high. All selects come out of registers, so they follow the address by one clock.

The code blocks share one size, picked by a two-bit code. That size is counted in bytes on a byte-organised host. On a 16-bit host it is counted in half as many words, and the RAM capacity halves in the same way. RAM and the two I/O windows may sit on top of code blocks and win over them, so a shadowed code location cannot be reached. The decoder also checks the programmed map on every cycle. A registered error flag goes high when code windows overlap, when RAM and I/O windows overlap, when a window is longer than its memory, or when the size code is reserved. Decoding goes on even while the flag is high, and the fixed priority still keeps the selects one-hot.

Top module: `memsel_decoder`

## Requirements
- R1: While reset is asserted, and on the first sampled cycle after it, every select output and `cfg_err_o` is 0.
- R2: When `qual_i` is 1 and the address satisfies base <= addr < base+len for code window k (len non-zero), and no RAM or I/O window matches, `cs_code_o[k]` is 1 in the following cycle and every other select is 0.
- R3: When `qual_i` is 0, or when no enabled window matches the address, all selects are 0 in the following cycle.
- R4: At most one of the seven select bits (`cs_code_o[3:0]`, `cs_ram_o`, `cs_iio_o`, `cs_pio_o`) is 1 in any cycle.
- R5: A matching RAM, internal I/O or peripheral I/O window wins over any matching code window, so the code select stays 0. Among RAM/I/O windows the order is RAM, then internal I/O, then peripheral I/O. Among code windows the lowest index wins.
- R6: The peripheral I/O window matches, and is counted in the overlap check, only while `periph_en_i` is 1.
- R7: The code block span is 8192 << `blk_size_i` units for `blk_size_i` = 0, 1 or 2 (8K, 16K or 32K bytes), halved when `wide_i` = 1 (16-bit words). A code window length above that span sets `cfg_err_o`.
- R8: A RAM window length above 2048 units (`wide_i` = 0) or 1024 units (`wide_i` = 1) sets `cfg_err_o`.
- R9: Any two enabled code windows that share an address set `cfg_err_o`.
- R10: Any two enabled windows among RAM, internal I/O and peripheral I/O that share an address set `cfg_err_o`.
- R11: `blk_size_i` = 3 is reserved and sets `cfg_err_o`. The flag follows its inputs with a one-cycle delay and is 0 for a legal map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Host address in addressable units |
| qual_i | input | 1 | Access qualifier; selects only when 1 |
| wide_i | input | 1 | 0 = byte organisation, 1 = 16-bit word organisation |
| blk_size_i | input | 2 | Code block size code: 0 = 8K, 1 = 16K, 2 = 32K bytes, 3 reserved |
| periph_en_i | input | 1 | Enables the peripheral I/O window |
| code_base_i | input | N_CODE x ADDR_W | Base address of each code window |
| code_len_i | input | N_CODE x ADDR_W | Length of each code window (0 = off) |
| ram_base_i | input | ADDR_W | Scratch RAM base |
| ram_len_i | input | ADDR_W | Scratch RAM length (0 = off) |
| iio_base_i | input | ADDR_W | Internal I/O base |
| iio_len_i | input | ADDR_W | Internal I/O length (0 = off) |
| pio_base_i | input | ADDR_W | Peripheral I/O base |
| pio_len_i | input | ADDR_W | Peripheral I/O length (0 = off) |
| cs_code_o | output | N_CODE | Code block selects |
| cs_ram_o | output | 1 | Scratch RAM select |
| cs_iio_o | output | 1 | Internal I/O select |
| cs_pio_o | output | 1 | Peripheral I/O select |
| cfg_err_o | output | 1 | Illegal memory map flag |

## Verification
The assertions check on every cycle that the selects stay one-hot, that a cycle without the qualifier yields no select, and that a RAM or I/O hit keeps every code select low. They also check that the peripheral select stays low while its enable is low and that the reserved size code raises the error flag. The bench scenarios are needed to show the exact window edges (first and last unit, one past the end), the shadowed part of a code block, word organisation, and each overlap and length fault. The lowered flag on a legal map is shown there as well.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
    typedef enum logic [2:0] {
        W_NONE,
        W_RAM,
        W_IIO,
        W_PIO,
        W_CODE
    } winner_e;
endpackage

// File: rtl/memsel_range.sv
module memsel_range #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic              en_i,
    output logic              hit_o
);
    localparam int LW = ADDR_W + 1;
    logic [LW-1:0] offset;

    always_comb begin
        offset = {1'b0, addr_i} - {1'b0, base_i};
        hit_o  = en_i && (len_i != '0) && (addr_i >= base_i) && (offset < {1'b0, len_i});
    end
endmodule

// File: rtl/memsel_overlap.sv
module memsel_overlap #(
    parameter int ADDR_W = 20,
    parameter int N      = 4
) (
    input  logic [N-1:0][ADDR_W-1:0] base_i,
    input  logic [N-1:0][ADDR_W-1:0] len_i,
    input  logic [N-1:0]             en_i,
    output logic                     ovl_o
);
    localparam int LW = ADDR_W + 1;
    logic [N-1:0][LW-1:0] top;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            top[i] = {1'b0, base_i[i]} + {1'b0, len_i[i]};
        end
        ovl_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (en_i[i] && en_i[j] && (len_i[i] != '0) && (len_i[j] != '0) &&
                    ({1'b0, base_i[i]} < top[j]) && ({1'b0, base_i[j]} < top[i])) begin
                    ovl_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/memsel_priority.sv
module memsel_priority
    import memsel_pkg::*;
#(
    parameter int N_CODE = 4,
    parameter int IW     = 2
) (
    input  logic              qual_i,
    input  logic [N_CODE-1:0] code_hit_i,
    input  logic              ram_hit_i,
    input  logic              iio_hit_i,
    input  logic              pio_hit_i,
    output winner_e           win_o,
    output logic [IW-1:0]     idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N_CODE - 1; i >= 0; i--) begin
            if (code_hit_i[i]) idx_o = IW'(i);
        end
        if (!qual_i)               win_o = W_NONE;
        else if (ram_hit_i)        win_o = W_RAM;
        else if (iio_hit_i)        win_o = W_IIO;
        else if (pio_hit_i)        win_o = W_PIO;
        else if (|code_hit_i)      win_o = W_CODE;
        else                       win_o = W_NONE;
    end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int N_CODE    = 4,
    parameter int CODE_UNIT = 8192,
    parameter int RAM_BYTES = 2048
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          qual_i,
    input  logic                          wide_i,
    input  logic [1:0]                    blk_size_i,
    input  logic                          periph_en_i,
    input  logic [N_CODE-1:0][ADDR_W-1:0] code_base_i,
    input  logic [N_CODE-1:0][ADDR_W-1:0] code_len_i,
    input  logic [ADDR_W-1:0]             ram_base_i,
    input  logic [ADDR_W-1:0]             ram_len_i,
    input  logic [ADDR_W-1:0]             iio_base_i,
    input  logic [ADDR_W-1:0]             iio_len_i,
    input  logic [ADDR_W-1:0]             pio_base_i,
    input  logic [ADDR_W-1:0]             pio_len_i,
    output logic [N_CODE-1:0]             cs_code_o,
    output logic                          cs_ram_o,
    output logic                          cs_iio_o,
    output logic                          cs_pio_o,
    output logic                          cfg_err_o
);
    localparam int LW = ADDR_W + 1;
    localparam int IW = (N_CODE > 1) ? $clog2(N_CODE) : 1;
    localparam logic [LW-1:0] UNIT_L = LW'(CODE_UNIT);
    localparam logic [LW-1:0] RAM_L  = LW'(RAM_BYTES);

    logic [N_CODE-1:0] code_hit;
    logic              ram_hit, iio_hit, pio_hit;
    winner_e           win;
    logic [IW-1:0]     win_idx;

    // Range comparators, one per code window
    for (genvar g = 0; g < N_CODE; g++) begin : g_code
        memsel_range #(.ADDR_W(ADDR_W)) i_rng (
            .addr_i(addr_i), .base_i(code_base_i[g]), .len_i(code_len_i[g]),
            .en_i(1'b1), .hit_o(code_hit[g])
        );
    end

    memsel_range #(.ADDR_W(ADDR_W)) i_ram_rng (
        .addr_i(addr_i), .base_i(ram_base_i), .len_i(ram_len_i),
        .en_i(1'b1), .hit_o(ram_hit)
    );
    memsel_range #(.ADDR_W(ADDR_W)) i_iio_rng (
        .addr_i(addr_i), .base_i(iio_base_i), .len_i(iio_len_i),
        .en_i(1'b1), .hit_o(iio_hit)
    );
    memsel_range #(.ADDR_W(ADDR_W)) i_pio_rng (
        .addr_i(addr_i), .base_i(pio_base_i), .len_i(pio_len_i),
        .en_i(periph_en_i), .hit_o(pio_hit)
    );

    memsel_priority #(.N_CODE(N_CODE), .IW(IW)) i_prio (
        .qual_i(qual_i), .code_hit_i(code_hit), .ram_hit_i(ram_hit),
        .iio_hit_i(iio_hit), .pio_hit_i(pio_hit), .win_o(win), .idx_o(win_idx)
    );

    // Map legality
    logic code_ovl, rio_ovl;

    memsel_overlap #(.ADDR_W(ADDR_W), .N(N_CODE)) i_code_ovl (
        .base_i(code_base_i), .len_i(code_len_i), .en_i({N_CODE{1'b1}}), .ovl_o(code_ovl)
    );
    memsel_overlap #(.ADDR_W(ADDR_W), .N(3)) i_rio_ovl (
        .base_i({pio_base_i, iio_base_i, ram_base_i}),
        .len_i({pio_len_i, iio_len_i, ram_len_i}),
        .en_i({periph_en_i, 2'b11}), .ovl_o(rio_ovl)
    );

    logic [LW-1:0] code_span, ram_span;
    logic          size_bad, len_bad, err_d;

    always_comb begin
        code_span = (UNIT_L << blk_size_i) >> wide_i;
        ram_span  = RAM_L >> wide_i;
        size_bad  = (blk_size_i == 2'd3);
        len_bad   = ({1'b0, ram_len_i} > ram_span);
        for (int i = 0; i < N_CODE; i++) begin
            if ({1'b0, code_len_i[i]} > code_span) len_bad = 1'b1;
        end
        err_d = size_bad || len_bad || code_ovl || rio_ovl;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_code_o <= '0;
            cs_ram_o  <= 1'b0;
            cs_iio_o  <= 1'b0;
            cs_pio_o  <= 1'b0;
            cfg_err_o <= 1'b0;
        end else begin
            cs_code_o <= '0;
            cs_ram_o  <= 1'b0;
            cs_iio_o  <= 1'b0;
            cs_pio_o  <= 1'b0;
            cfg_err_o <= err_d;
            unique case (win)
                W_NONE: ;
                W_RAM:  cs_ram_o <= 1'b1;
                W_IIO:  cs_iio_o <= 1'b1;
                W_PIO:  cs_pio_o <= 1'b1;
                W_CODE: cs_code_o[win_idx] <= 1'b1;
                default: ;
            endcase
        end
    end

    // Checks beside the logic they guard
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_code_o, cs_ram_o, cs_iio_o, cs_pio_o}));

    p_noqual_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_i |=> ({cs_code_o, cs_ram_o, cs_iio_o, cs_pio_o} == '0));

    p_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_i && (ram_hit || iio_hit)) |=> (cs_code_o == '0));

    p_pio_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en_i |=> !cs_pio_o);

    p_bad_size_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_size_i == 2'd3) |=> cfg_err_o);
endmodule

// File: tb/test_memsel_decoder.sv
module test_memsel_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] addr;
    logic qual, wide, periph_en;
    logic [1:0] blk_size;
    logic [3:0][AW-1:0] code_base, code_len;
    logic [AW-1:0] ram_base, ram_len, iio_base, iio_len, pio_base, pio_len;
    logic [3:0] cs_code;
    logic cs_ram, cs_iio, cs_pio, cfg_err;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memsel_decoder i_memsel_decoder (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .qual_i(qual), .wide_i(wide),
        .blk_size_i(blk_size), .periph_en_i(periph_en),
        .code_base_i(code_base), .code_len_i(code_len),
        .ram_base_i(ram_base), .ram_len_i(ram_len),
        .iio_base_i(iio_base), .iio_len_i(iio_len),
        .pio_base_i(pio_base), .pio_len_i(pio_len),
        .cs_code_o(cs_code), .cs_ram_o(cs_ram), .cs_iio_o(cs_iio),
        .cs_pio_o(cs_pio), .cfg_err_o(cfg_err)
    );

    // {addr, qual, expected {pio, iio, ram, code[3:0]}}
    localparam logic [27:0] VEC [16] = '{
        {20'h00000, 1'b1, 7'b000_0001},   // R2 first unit of code0
        {20'h00FFF, 1'b1, 7'b000_0001},   // R2
        {20'h01000, 1'b1, 7'b001_0000},   // R5 RAM over code0
        {20'h017FF, 1'b1, 7'b001_0000},   // R5 last RAM unit
        {20'h01800, 1'b1, 7'b000_0001},   // R2 past RAM end
        {20'h02000, 1'b1, 7'b000_0010},   // R2 code1
        {20'h03000, 1'b1, 7'b010_0000},   // R5 internal I/O over code1
        {20'h030FF, 1'b1, 7'b010_0000},   // R5
        {20'h03100, 1'b1, 7'b000_0010},   // R2
        {20'h05000, 1'b1, 7'b100_0000},   // R5/R6 peripheral over code2
        {20'h04000, 1'b1, 7'b000_0100},   // R2 code2
        {20'h07FFF, 1'b1, 7'b000_1000},   // R2 last unit of code3
        {20'h08000, 1'b1, 7'b000_0000},   // R3 no match
        {20'h04000, 1'b0, 7'b000_0000},   // R3 unqualified
        {20'hFFFFF, 1'b1, 7'b000_0000},   // R3 top of space
        {20'h06000, 1'b1, 7'b000_1000}    // R2 code3 base
    };

    function automatic logic [6:0] sel_vec();
        return {cs_pio, cs_iio, cs_ram, cs_code};
    endfunction

    task automatic check_sel(input logic [6:0] exp, input string req);
        n_run++;
        if (sel_vec() !== exp) begin
            n_fail++;
            $display("FAIL %s selects actual=%b expected=%b", req, sel_vec(), exp);
        end
    endtask

    task automatic check_err(input logic exp, input string req);
        n_run++;
        if (cfg_err !== exp) begin
            n_fail++;
            $display("FAIL %s cfg_err actual=%b expected=%b", req, cfg_err, exp);
        end
    endtask

    task automatic legal_map();
        wide = 1'b0; blk_size = 2'd0; periph_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            code_base[i] = AW'(i * 32'h2000);
            code_len[i]  = 20'h02000;
        end
        ram_base = 20'h01000; ram_len = 20'h00800;
        iio_base = 20'h03000; iio_len = 20'h00100;
        pio_base = 20'h05000; pio_len = 20'h00100;
    endtask

    // Apply at a falling edge, sample at the next falling edge (one register)
    task automatic step();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; qual = 1'b1; addr = 20'h00000;
        legal_map();
        blk_size = 2'd3;   // would raise the flag if reset were ignored
        repeat (3) @(negedge clk);
        check_sel(7'b0, "R1");
        check_err(1'b0, "R1");
        rst_n = 1'b1;
        legal_map();
        step();
        check_err(1'b0, "R1");
        check_err(1'b0, "R11 legal map");

        foreach (VEC[k]) begin
            addr = VEC[k][27:8];
            qual = VEC[k][7];
            step();
            check_sel(VEC[k][6:0], "R2/R3/R5 table");
        end
        qual = 1'b1;

        // R6: peripheral window gated off, code2 shows through
        periph_en = 1'b0; addr = 20'h05000;
        step();
        check_sel(7'b000_0100, "R6");

        // R5 ordering: RAM over internal I/O when both match (illegal map)
        legal_map(); iio_base = 20'h01000;
        addr = 20'h01000;
        step();
        check_sel(7'b001_0000, "R5 RAM over IIO");
        check_err(1'b1, "R10 RAM/IIO overlap");

        // R10: peripheral overlap counts only when enabled
        legal_map(); pio_base = 20'h03080; periph_en = 1'b0;
        step();
        check_err(1'b0, "R10 pio disabled");
        periph_en = 1'b1;
        step();
        check_err(1'b1, "R10 pio enabled");

        // R9: code windows overlap by one unit
        legal_map(); code_base[1] = 20'h01FFF;
        step();
        check_err(1'b1, "R9");
        addr = 20'h01FFF;
        step();
        check_sel(7'b000_0001, "R5 lowest code index");

        // R7: code window one unit longer than an 8K block
        legal_map(); code_len[3] = 20'h02001;
        step();
        check_err(1'b1, "R7 byte");
        legal_map(); blk_size = 2'd1; code_len[3] = 20'h02001;
        step();
        check_err(1'b0, "R7 16K block");

        // R7 word organisation: 8K bytes is 4K words
        legal_map(); wide = 1'b1;
        step();
        check_err(1'b1, "R7 word span");
        for (int i = 0; i < 4; i++) begin
            code_base[i] = AW'(i * 32'h1000);
            code_len[i]  = 20'h01000;
        end
        ram_base = 20'h08000; ram_len = 20'h00400;
        iio_base = 20'h09000; pio_base = 20'h0A000;
        addr = 20'h01000;
        step();
        check_err(1'b0, "R7 word legal");
        check_sel(7'b000_0010, "R7 word decode");

        // R8: RAM length limits
        ram_len = 20'h00401;
        step();
        check_err(1'b1, "R8 word");
        legal_map(); ram_len = 20'h00801;
        step();
        check_err(1'b1, "R8 byte");

        // R11: reserved size code
        legal_map(); blk_size = 2'd3;
        step();
        check_err(1'b1, "R11");
        blk_size = 2'd0;
        step();
        check_err(1'b0, "R11 clears");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule